// File: doc/BRIEF.md
# Duplicated-Bit Return Channel Codec

This block moves a handful of status and command bits from the receiving end of a link back to the transmitting end over a 16-bit word path. There is no flag bit and no control-word type: every word is a plain data word. Error protection comes from redundancy. Each of eight logical bits is placed twice, in two adjacent word bits. A received word is used only when every pair agrees.

The encoder side takes four user return lines and three requests: flow-control off, far side down and remote reset. It emits one encoded word and then leaves seven idle slots, so one slot in eight carries a word. The decoder side checks the eight pairs of each incoming word. On a clean word it updates registered outputs and pulses a one-cycle strobe. On a word with any broken pair it leaves the outputs untouched and bumps a saturating discard counter. Serialization, clock recovery and clock-domain synchronization of the outputs belong to the surrounding logic.

Top module: `rc_codec`

## Requirements
- R1: In an encoded word, return line k (k = 0..3) occupies bits 2k+1 and 2k. Both bits are 1 when the line is high and 0 when it is low.
- R2: Flow-control off occupies bits 9:8, far side down occupies bits 11:10 and remote reset occupies bits 13:12, each duplicated the same way. The reserved bits 15:14 are always sent as 00.
- R3: After reset release, `tx_valid` is high for the cycle following the 1st, 9th, 17th… rising edge (one cycle in every eight) and low otherwise. `tx_word` is all zeros whenever `tx_valid` is low.
- R4: A word that is sent encodes the request inputs as they stood at the clock edge that opened that slot.
- R5: A word presented with `rx_valid` high whose eight pairs (bits 2k+1 and 2k) all agree is accepted. In the next cycle, `rx_lines[k]` equals bit 2k+1, `rx_xoff` equals bit 9, `rx_far_down` equals bit 11 and `rx_remote_rst` equals bit 13, and `rx_accept` is high for exactly that cycle. `rx_word` is ignored while `rx_valid` is low.
- R6: A word presented with `rx_valid` high in which any pair disagrees is discarded. The decoded outputs keep their previous values and `rx_accept` stays low.
- R7: A word whose reserved pair is 11 and whose other pairs agree is accepted like any other clean word.
- R8: `rx_drop_count` increases by exactly one for each discarded word and holds at its all-ones value once reached.
- R9: During and right after reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both halves |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_lines | input | 4 | User return lines to send |
| tx_xoff | input | 1 | Flow-control off request to send |
| tx_far_down | input | 1 | Far-side-down indication to send |
| tx_remote_rst | input | 1 | Remote reset request to send |
| tx_word | output | 16 | Encoded word, zero in idle slots |
| tx_valid | output | 1 | High in the one slot of eight that carries a word |
| rx_word | input | 16 | Received word |
| rx_valid | input | 1 | Received word present this cycle |
| rx_lines | output | 4 | Last accepted return lines |
| rx_xoff | output | 1 | Last accepted flow-control off |
| rx_far_down | output | 1 | Last accepted far-side-down |
| rx_remote_rst | output | 1 | Last accepted remote reset |
| rx_accept | output | 1 | One-cycle strobe per accepted word |
| rx_drop_count | output | DROP_W | Saturating count of discarded words |

## Verification
The assertions assume that reset is held for at least one clock edge and that the inputs settle before each rising edge. They place no constraint on the contents of `rx_word`, so arbitrary corruption, reserved-field values and garbage during idle cycles are all legal. The stimulus changes inputs only one time unit after a rising edge. It drives deliberately broken pairs in every pair position, a reserved field of 11 and noise with `rx_valid` low. It also sends enough bad words to saturate the counter, which stays within the condition that the discard counter only sees `rx_valid`-qualified words.

// File: rtl/rc_pkg.sv
package rc_pkg;
  localparam int RC_WORD_W = 16;
  localparam int RC_PAIRS  = RC_WORD_W / 2;
  localparam int RC_LINES  = 4;

  // Bit i of this struct maps to word pair i (bits 2i+1, 2i).
  typedef struct packed {
    logic                rsv;
    logic                rmt_rst;
    logic                far_down;
    logic                xoff;
    logic [RC_LINES-1:0] lines;
  } rc_bits_t;

  function automatic logic [RC_WORD_W-1:0] rc_spread(rc_bits_t b);
    logic [RC_PAIRS-1:0]  v;
    logic [RC_WORD_W-1:0] w;
    v = b;
    w = '0;
    for (int i = 0; i < RC_PAIRS; i++) begin
      w[2*i]   = v[i];
      w[2*i+1] = v[i];
    end
    return w;
  endfunction

  function automatic rc_bits_t rc_collapse(logic [RC_WORD_W-1:0] w);
    logic [RC_PAIRS-1:0] v;
    for (int i = 0; i < RC_PAIRS; i++) v[i] = w[2*i+1];
    return rc_bits_t'(v);
  endfunction
endpackage

// File: rtl/rc_tx_enc.sv
module rc_tx_enc
  import rc_pkg::*;
#(
  parameter int PERIOD = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  rc_bits_t             req,
  output logic [RC_WORD_W-1:0] word,
  output logic                 valid,
  output logic                 slot_start
);
  localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt;
  rc_bits_t      req_clean;

  assign slot_start = (cnt == '0);

  always_comb begin
    req_clean     = req;
    req_clean.rsv = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      word  <= '0;
      valid <= 1'b0;
    end else begin
      cnt   <= (cnt == LAST) ? '0 : cnt + CW'(1);
      valid <= slot_start;
      word  <= slot_start ? rc_spread(req_clean) : '0;
    end
  end
endmodule

// File: rtl/rc_rx_dec.sv
module rc_rx_dec
  import rc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [RC_WORD_W-1:0] word,
  input  logic                 valid,
  output rc_bits_t             held,
  output logic                 accept,
  output logic                 word_bad
);
  logic [RC_PAIRS-1:0] pair_err;
  logic                word_ok;

  for (genvar g = 0; g < RC_PAIRS; g++) begin : g_pair
    assign pair_err[g] = word[2*g] ^ word[2*g+1];
  end

  assign word_ok  = valid && (pair_err == '0);
  assign word_bad = valid && (|pair_err);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held   <= '0;
      accept <= 1'b0;
    end else begin
      accept <= word_ok;
      if (word_ok) held <= rc_collapse(word);
    end
  end
endmodule

// File: rtl/rc_drop_ctr.sv
module rc_drop_ctr #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bump,
  output logic [W-1:0] count
);
  always_ff @(posedge clk) begin
    if (!rst_n)                      count <= '0;
    else if (bump && (count != '1))  count <= count + W'(1);
  end
endmodule

// File: rtl/rc_codec.sv
module rc_codec
  import rc_pkg::*;
#(
  parameter int PERIOD = 8,
  parameter int DROP_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        tx_lines,
  input  logic              tx_xoff,
  input  logic              tx_far_down,
  input  logic              tx_remote_rst,
  output logic [15:0]       tx_word,
  output logic              tx_valid,
  input  logic [15:0]       rx_word,
  input  logic              rx_valid,
  output logic [3:0]        rx_lines,
  output logic              rx_xoff,
  output logic              rx_far_down,
  output logic              rx_remote_rst,
  output logic              rx_accept,
  output logic [DROP_W-1:0] rx_drop_count
);
  rc_bits_t tx_req;
  rc_bits_t rx_held;
  logic     tx_slot_start;
  logic     rx_word_bad;

  always_comb begin
    tx_req          = '0;
    tx_req.lines    = tx_lines;
    tx_req.xoff     = tx_xoff;
    tx_req.far_down = tx_far_down;
    tx_req.rmt_rst  = tx_remote_rst;
  end

  rc_tx_enc #(.PERIOD(PERIOD)) u_enc (
    .clk(clk), .rst_n(rst_n), .req(tx_req),
    .word(tx_word), .valid(tx_valid), .slot_start(tx_slot_start)
  );

  rc_rx_dec u_dec (
    .clk(clk), .rst_n(rst_n), .word(rx_word), .valid(rx_valid),
    .held(rx_held), .accept(rx_accept), .word_bad(rx_word_bad)
  );

  rc_drop_ctr #(.W(DROP_W)) u_drop (
    .clk(clk), .rst_n(rst_n), .bump(rx_word_bad), .count(rx_drop_count)
  );

  assign rx_lines      = rx_held.lines;
  assign rx_xoff       = rx_held.xoff;
  assign rx_far_down   = rx_held.far_down;
  assign rx_remote_rst = rx_held.rmt_rst;
endmodule

// File: rtl/rc_codec_chk.sv
module rc_codec_chk #(
  parameter int PERIOD = 8,
  parameter int DROP_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [15:0]       tx_word,
  input logic              tx_valid,
  input logic [15:0]       rx_word,
  input logic              rx_valid,
  input logic [3:0]        rx_lines,
  input logic              rx_xoff,
  input logic              rx_far_down,
  input logic              rx_remote_rst,
  input logic              rx_accept,
  input logic [DROP_W-1:0] rx_drop_count
);
  localparam int GW = $clog2(PERIOD + 1) + 1;
  logic [GW-1:0] since_tx;
  logic          seen_tx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_tx <= '0;
      seen_tx  <= 1'b0;
    end else if (tx_valid) begin
      since_tx <= GW'(1);
      seen_tx  <= 1'b1;
    end else if (since_tx != '1) begin
      since_tx <= since_tx + GW'(1);
    end
  end

  // R3
  tx_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && seen_tx) |-> (since_tx == GW'(PERIOD)));
  // R3
  tx_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |=> !tx_valid);
  // R3
  tx_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_valid |-> (tx_word == 16'h0000));
  // R2
  tx_rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (tx_word[15:14] == 2'b00));
  // R1
  tx_pairs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (((tx_word ^ {1'b0, tx_word[15:1]}) & 16'h5555) == 16'h0000));
  // R5
  rx_accept_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_accept |-> ($past(rx_valid) &&
      ((($past(rx_word) ^ {1'b0, $past(rx_word[15:1])}) & 16'h5555) == 16'h0000)));
  // R6
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_accept |-> $stable({rx_lines, rx_xoff, rx_far_down, rx_remote_rst}));
  // R8
  drop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_drop_count == $past(rx_drop_count)) ||
    (rx_drop_count == $past(rx_drop_count) + DROP_W'(1)));
  // R8
  drop_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rx_drop_count) == '1) |-> (rx_drop_count == '1));
  // R8
  drop_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_drop_count != $past(rx_drop_count)) |-> ($past(rx_valid) && !rx_accept));
endmodule

bind rc_codec rc_codec_chk #(.PERIOD(PERIOD), .DROP_W(DROP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_word(tx_word), .tx_valid(tx_valid),
  .rx_word(rx_word), .rx_valid(rx_valid), .rx_lines(rx_lines),
  .rx_xoff(rx_xoff), .rx_far_down(rx_far_down), .rx_remote_rst(rx_remote_rst),
  .rx_accept(rx_accept), .rx_drop_count(rx_drop_count)
);

// File: tb/rc_codec_tb.sv
module rc_codec_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  tx_lines = '0;
  logic        tx_xoff = 1'b0, tx_far_down = 1'b0, tx_remote_rst = 1'b0;
  logic [15:0] tx_word;
  logic        tx_valid;
  logic [15:0] rx_word = '0;
  logic        rx_valid = 1'b0;
  logic [3:0]  rx_lines;
  logic        rx_xoff, rx_far_down, rx_remote_rst, rx_accept;
  logic [3:0]  rx_drop_count;

  int n_cmp = 0;
  int n_bad = 0;
  int edges = 0;
  int m_txv = 0, m_txw = 0;
  int m_lines = 0, m_xoff = 0, m_down = 0, m_rrst = 0, m_acc = 0, m_cnt = 0;

  always #5 clk = ~clk;

  rc_codec u_dut (
    .clk(clk), .rst_n(rst_n), .tx_lines(tx_lines), .tx_xoff(tx_xoff),
    .tx_far_down(tx_far_down), .tx_remote_rst(tx_remote_rst),
    .tx_word(tx_word), .tx_valid(tx_valid), .rx_word(rx_word),
    .rx_valid(rx_valid), .rx_lines(rx_lines), .rx_xoff(rx_xoff),
    .rx_far_down(rx_far_down), .rx_remote_rst(rx_remote_rst),
    .rx_accept(rx_accept), .rx_drop_count(rx_drop_count)
  );

  task automatic cmp(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int dup(int b, int pos);
    return b ? (3 << pos) : 0;
  endfunction

  function automatic int build(int lines, int xo, int dn, int rr, int rsv);
    int w = 0;
    for (int k = 0; k < 4; k++) w += dup((lines >> k) & 1, 2 * k);
    return w + dup(xo, 8) + dup(dn, 10) + dup(rr, 12) + dup(rsv, 14);
  endfunction

  task automatic compare_all();
    cmp("R3 tx_valid", int'(tx_valid), m_txv);
    cmp("R1 R2 R4 tx_word", int'(tx_word), m_txw);
    cmp("R5 rx_lines", int'(rx_lines), m_lines);
    cmp("R5 rx_xoff", int'(rx_xoff), m_xoff);
    cmp("R5 rx_far_down", int'(rx_far_down), m_down);
    cmp("R5 rx_remote_rst", int'(rx_remote_rst), m_rrst);
    cmp("R5 R6 rx_accept", int'(rx_accept), m_acc);
    cmp("R8 rx_drop_count", int'(rx_drop_count), m_cnt);
  endtask

  task automatic step();
    @(posedge clk);
    m_txv = ((edges % 8) == 0) ? 1 : 0;
    m_txw = m_txv ? build(int'(tx_lines), tx_xoff, tx_far_down, tx_remote_rst, 0) : 0;
    edges++;
    m_acc = 0;
    if (rx_valid) begin
      bit ok = 1'b1;
      for (int k = 0; k < 8; k++)
        if (rx_word[2*k] != rx_word[2*k+1]) ok = 1'b0;
      if (ok) begin
        m_acc   = 1;
        m_lines = {rx_word[7], rx_word[5], rx_word[3], rx_word[1]};
        m_xoff  = rx_word[9];
        m_down  = rx_word[11];
        m_rrst  = rx_word[13];
      end else if (m_cnt < 15) begin
        m_cnt++;
      end
    end
    #1;
    compare_all();
  endtask

  task automatic send(int w, bit v);
    rx_word  = w[15:0];
    rx_valid = v;
    step();
  endtask

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL R3 watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int snap;
    repeat (3) @(posedge clk);
    #1;
    // R9 reset state
    cmp("R9 tx_valid", int'(tx_valid), 0);
    cmp("R9 tx_word", int'(tx_word), 0);
    cmp("R9 rx_outputs", int'({rx_lines, rx_xoff, rx_far_down, rx_remote_rst, rx_accept}), 0);
    cmp("R9 rx_drop_count", int'(rx_drop_count), 0);
    rst_n = 1'b1;

    // R1 R2 R3 R4: encoder under changing requests, rx idle with noise (R5 ignored)
    for (int i = 0; i < 64; i++) begin
      tx_lines      = 4'((i * 7 + 3) % 16);
      tx_xoff       = i[1];
      tx_far_down   = i[2] ^ i[0];
      tx_remote_rst = i[3];
      rx_word       = 16'((i * 40503) % 65536);
      rx_valid      = 1'b0;
      step();
    end
    // R5: rx_valid low must not have changed anything
    cmp("R5 ignored-noise rx_accept_count", m_acc, 0);

    // R5 clean words of varied content
    for (int i = 0; i < 16; i++) begin
      send(build(i, i & 1, (i >> 1) & 1, (i >> 2) & 1, 0), 1'b1);
      cmp("R5 strobe", int'(rx_accept), 1);
      send(16'hFFFF ^ (i * 3), 1'b0);
      cmp("R5 strobe-one-cycle", int'(rx_accept), 0);
    end
    send(build(15, 1, 1, 1, 0), 1'b1);

    // R6: one broken pair in each position
    for (int k = 0; k < 8; k++) begin
      snap = int'({rx_lines, rx_xoff, rx_far_down, rx_remote_rst});
      send(build(0, 0, 0, 0, 0) ^ (1 << (2 * k + (k & 1))), 1'b1);
      cmp("R6 outputs-held", int'({rx_lines, rx_xoff, rx_far_down, rx_remote_rst}), snap);
      cmp("R6 no-strobe", int'(rx_accept), 0);
      send(0, 1'b0);
    end
    cmp("R8 count-after-8", int'(rx_drop_count), 8);

    // R7 reserved field 11
    send(build(5, 0, 1, 0, 1), 1'b1);
    cmp("R7 reserved-11-accepted", int'(rx_accept), 1);
    cmp("R7 lines", int'(rx_lines), 5);

    // R8 saturation
    for (int i = 0; i < 12; i++) send(16'h0001 << (i % 16), 1'b1);
    cmp("R8 saturated", int'(rx_drop_count), 15);
    send(16'h8000, 1'b1);
    cmp("R8 stays-saturated", int'(rx_drop_count), 15);

    // clean word still accepted after saturation
    send(build(10, 1, 0, 1, 0), 1'b1);
    cmp("R5 after-saturation", int'(rx_lines), 10);
    for (int i = 0; i < 10; i++) send(0, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule